// File: doc/BRIEF.md
# Field-Paced Full-Duplex Serial Link Master

This block drives one end of a clock-synchronous, full-duplex serial link to a peripheral controller. A frame-sync pulse, normally one per video field, opens a frame. The block raises chip select and then exchanges a fixed number of bytes (25 by default). Each exchange happens in its own fixed-length byte slot. In one slot, eight serial clocks shift a byte out on the data-out line and shift the peer's reply in on the data-in line, most significant bit first. The master generates the serial clock.

The peer can hold off a transfer by raising its busy line. The master checks busy at the start of every slot. If busy is high, the master leaves that slot idle and offers the same byte index again one slot later. When the last byte has been exchanged, chip select falls and a one-cycle done pulse marks that the receive buffer holds the complete reply frame. If a new frame-sync arrives while a frame is still open, the open frame is abandoned, an overrun pulse is given and a fresh frame starts at byte 0.

The controller FSM has four states:
- `ST_IDLE`: chip select is low.
- `ST_CHECK`: the one-cycle busy test at the start of a slot.
- `ST_SHIFT`: eight serial clocks are running.
- `ST_WAIT`: the master waits for the next slot boundary.

Its transitions are:
- open: `ST_IDLE`→`ST_CHECK` on a sync edge.
- go: `ST_CHECK`→`ST_SHIFT` when busy is low.
- skip: `ST_CHECK`→`ST_WAIT` when busy is high.
- next: `ST_SHIFT`→`ST_WAIT` after a byte that is not the last.
- close: `ST_SHIFT`→`ST_IDLE` after the last byte.
- slot: `ST_WAIT`→`ST_CHECK` at a slot boundary.
- restart: any open state→`ST_CHECK` on a sync edge.

Top module: `field_link_master`

## Requirements
- R1: After reset, `cs_o`, `frame_done_o` and `overrun_o` are low and `sclk_o` is high.
- R2: A rising edge on `frame_sync_i` while idle raises `cs_o` in the next cycle. The first slot begins at once, so the first falling edge of `sclk_o` comes `HALF_DIV`+1 cycles after `cs_o` rises.
- R3: Each byte is sent on `dout_o` most significant bit first, with 8 serial clock periods per byte. `dout_o` changes on the falling edge of `sclk_o`, and each low and high phase of `sclk_o` lasts `HALF_DIV` cycles. `sclk_o` rests high between bytes and whenever `cs_o` is low.
- R4: `din_i` is sampled on each rising edge of `sclk_o`, most significant bit first. The byte received in the slot of index k is stored at receive address k.
- R5: Byte indices 0 to `NUM_BYTES`-1 go out in order, one per slot, and successive slots start exactly `SLOT_CYCLES` cycles apart.
- R6: If `busy_i` is high at the start of a slot, no serial clock runs in that slot and the same byte index is tried again at the next slot. Each skipped slot lengthens the frame by `SLOT_CYCLES`.
- R7: After the last byte, `cs_o` falls and `frame_done_o` is high for exactly that one cycle. With no skipped slot, `cs_o` is high for (`NUM_BYTES`-1)·`SLOT_CYCLES`+16·`HALF_DIV`+2 cycles.
- R8: A rising edge of `frame_sync_i` while `cs_o` is high abandons the open frame. `overrun_o` pulses for one cycle, `cs_o` stays high, and a full new frame runs from index 0.
- R9: Transmit bytes are written through `tx_wr_*`, and received bytes are read combinationally on `rx_rd_data` at `rx_rd_addr`.
- R10: Only a rising edge of `frame_sync_i` starts a frame. Holding it high starts one frame and causes no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync_i | input | 1 | Frame start request, rising-edge detected |
| tx_wr_en | input | 1 | Transmit buffer write strobe |
| tx_wr_addr | input | 5 | Transmit buffer write address |
| tx_wr_data | input | 8 | Transmit buffer write data |
| rx_rd_addr | input | 5 | Receive buffer read address |
| rx_rd_data | output | 8 | Receive buffer read data, combinational |
| frame_done_o | output | 1 | One-cycle pulse when a frame completes |
| overrun_o | output | 1 | One-cycle pulse when a frame is abandoned |
| cs_o | output | 1 | Chip select, high while a frame is open |
| sclk_o | output | 1 | Serial clock, idles high |
| dout_o | output | 1 | Serial data to the peer |
| din_i | input | 1 | Serial data from the peer |
| busy_i | input | 1 | Peer not ready, sampled at slot start |

## Verification
The bench counts register stages from the sync edge. The edge is sampled into `cs_o` after one clock, the shifter loads one clock later, and each serial clock phase takes `HALF_DIV` clocks. The registered end-of-byte flag adds one more clock before the FSM closes the frame. So the first serial fall is due `HALF_DIV`+1 cycles after chip select rises, and the frame closes after (`NUM_BYTES`-1)·`SLOT_CYCLES`+16·`HALF_DIV`+2 cycles. The bench uses these counts, and one extra `SLOT_CYCLES` for every skipped slot.

A peer model samples every output on the falling system clock. It records the cycle number of every serial clock edge, the chip select edges and the done and overrun pulses. Each check compares those recorded cycle counts and captured bytes with values computed in closed form from the requirements. No check waits on an arbitrary delay.

// File: rtl/flm_pkg.sv
package flm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_SHIFT = 2'd2,
        ST_WAIT  = 2'd3
    } flm_state_t;
endpackage

// File: rtl/flm_regfile.sv
module flm_regfile #(
    parameter int DEPTH = 25,
    parameter int WIDTH = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr <= TOP_ADDR)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = (raddr <= TOP_ADDR) ? mem[raddr] : '0;
    end
endmodule

// File: rtl/flm_slot_timer.sv
module flm_slot_timer #(
    parameter int SLOT_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_comb tick = (cnt == CNT_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: a boundary is a single cycle, never two in a row
    p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/flm_shifter.sv
module flm_shifter #(
    parameter int WIDTH    = 8,
    parameter int HALF_DIV = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [WIDTH-1:0] tx_byte,
    input  logic             din,
    output logic             sclk,
    output logic             dout,
    output logic [WIDTH-1:0] rx_byte,
    output logic             done
);
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [HW-1:0] HC_END = HW'(HALF_DIV - 1);
    localparam logic [BW-1:0] BC_END = BW'(WIDTH - 1);

    logic             active;
    logic [HW-1:0]    hc;
    logic [BW-1:0]    bc;
    logic [WIDTH-1:0] sh;

    always_comb rx_byte = sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            sclk   <= 1'b1;
            dout   <= 1'b1;
            sh     <= '0;
            hc     <= '0;
            bc     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                active <= 1'b0;
                sclk   <= 1'b1;
                hc     <= '0;
                bc     <= '0;
            end else if (start) begin
                active <= 1'b1;
                sclk   <= 1'b1;
                sh     <= tx_byte;
                hc     <= '0;
                bc     <= '0;
            end else if (active) begin
                if (hc == HC_END) begin
                    hc <= '0;
                    if (sclk) begin
                        sclk <= 1'b0;
                        dout <= sh[WIDTH-1];
                    end else begin
                        sclk <= 1'b1;
                        sh   <= {sh[WIDTH-2:0], din};
                        bc   <= bc + 1'b1;
                        if (bc == BC_END) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    hc <= hc + 1'b1;
                end
            end
        end
    end

    // R3: data only moves while the serial clock is low
    p_dout_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(dout));
    // R3: the clock rests high when no byte is in flight
    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> sclk);
endmodule

// File: rtl/field_link_master.sv
module field_link_master
    import flm_pkg::*;
#(
    parameter int NUM_BYTES   = 25,
    parameter int BYTE_W      = 8,
    parameter int CLK_HZ      = 125_000_000,
    parameter int BIT_RATE    = 1_680_000,
    parameter int SLOT_US     = 400,
    parameter int HALF_DIV    = CLK_HZ / (2 * BIT_RATE),
    parameter int SLOT_CYCLES = (CLK_HZ / 1_000_000) * SLOT_US,
    parameter int AW          = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync_i,
    input  logic              tx_wr_en,
    input  logic [AW-1:0]     tx_wr_addr,
    input  logic [BYTE_W-1:0] tx_wr_data,
    input  logic [AW-1:0]     rx_rd_addr,
    output logic [BYTE_W-1:0] rx_rd_data,
    output logic              frame_done_o,
    output logic              overrun_o,
    output logic              cs_o,
    output logic              sclk_o,
    output logic              dout_o,
    input  logic              din_i,
    input  logic              busy_i
);
    localparam logic [AW-1:0] IDX_END = AW'(NUM_BYTES - 1);

    flm_state_t        state, state_nx;
    logic              fs_q, fs_rise;
    logic [AW-1:0]     idx;
    logic              slot_tick, sh_done, sh_start, rx_we, last_idx;
    logic [BYTE_W-1:0] tx_byte, rx_byte;

    always_comb begin
        fs_rise  = frame_sync_i && !fs_q;
        last_idx = (idx == IDX_END);
        sh_start = (state == ST_CHECK) && !busy_i && !fs_rise;
        rx_we    = (state == ST_SHIFT) && sh_done && !fs_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= frame_sync_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (fs_rise) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (fs_rise)     state_nx = ST_CHECK;
                else if (busy_i) state_nx = ST_WAIT;
                else             state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (fs_rise)      state_nx = ST_CHECK;
                else if (sh_done) state_nx = last_idx ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: begin
                if (fs_rise || slot_tick) state_nx = ST_CHECK;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_o         <= 1'b0;
            frame_done_o <= 1'b0;
            overrun_o    <= 1'b0;
            idx          <= '0;
        end else begin
            frame_done_o <= 1'b0;
            overrun_o    <= 1'b0;
            if (fs_rise) begin
                cs_o      <= 1'b1;
                idx       <= '0;
                overrun_o <= (state != ST_IDLE);
            end else if ((state == ST_SHIFT) && sh_done) begin
                if (last_idx) begin
                    cs_o         <= 1'b0;
                    frame_done_o <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    flm_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fs_rise),
        .tick    (slot_tick)
    );

    flm_shifter #(.WIDTH(BYTE_W), .HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (fs_rise),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .din     (din_i),
        .sclk    (sclk_o),
        .dout    (dout_o),
        .rx_byte (rx_byte),
        .done    (sh_done)
    );

    flm_regfile #(.DEPTH(NUM_BYTES), .WIDTH(BYTE_W), .AW(AW)) u_txbuf (
        .clk   (clk),
        .we    (tx_wr_en),
        .waddr (tx_wr_addr),
        .wdata (tx_wr_data),
        .raddr (idx),
        .rdata (tx_byte)
    );

    flm_regfile #(.DEPTH(NUM_BYTES), .WIDTH(BYTE_W), .AW(AW)) u_rxbuf (
        .clk   (clk),
        .we    (rx_we),
        .waddr (idx),
        .wdata (rx_byte),
        .raddr (rx_rd_addr),
        .rdata (rx_rd_data)
    );

    // R3: no serial clock while chip select is low
    p_cs_low_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_o |-> sclk_o);
    // R7: chip select only drops together with the done pulse
    p_done_on_cs_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_o) |-> frame_done_o);
    p_done_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> !cs_o);
    // R6: a busy slot is left idle
    p_busy_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CHECK) && busy_i && !fs_rise) |=> ((state == ST_WAIT) && sclk_o));
    // R8: an abandoned frame keeps chip select asserted
    p_overrun_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> cs_o);
endmodule

// File: tb/field_link_master_tb.sv
module field_link_master_tb;
    localparam int NB = 25;
    localparam int H  = 2;
    localparam int S  = 40;
    localparam int FRAME_LEN = (NB - 1) * S + 16 * H + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       tx_wr_en = 1'b0;
    logic [4:0] tx_wr_addr = '0;
    logic [7:0] tx_wr_data = '0;
    logic [4:0] rx_rd_addr = '0;
    logic [7:0] rx_rd_data;
    logic       frame_done, overrun, cs, sclk, dout, busy = 1'b0;
    logic       din;

    int compared = 0;
    int mismatched = 0;
    int seed = 0;

    always #4 clk = ~clk;

    field_link_master #(.HALF_DIV(H), .SLOT_CYCLES(S)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync_i (frame_sync),
        .tx_wr_en     (tx_wr_en),
        .tx_wr_addr   (tx_wr_addr),
        .tx_wr_data   (tx_wr_data),
        .rx_rd_addr   (rx_rd_addr),
        .rx_rd_data   (rx_rd_data),
        .frame_done_o (frame_done),
        .overrun_o    (overrun),
        .cs_o         (cs),
        .sclk_o       (sclk),
        .dout_o       (dout),
        .din_i        (din),
        .busy_i       (busy)
    );

    function automatic logic [7:0] tx_pat(int s, int i);
        return 8'((i * 37 + s * 11 + 8'h5A) & 8'hFF);
    endfunction
    function automatic logic [7:0] rx_pat(int s, int i);
        return 8'(((i * 29) ^ (s * 77) ^ 8'hC3) & 8'hFF);
    endfunction

    // peer model and monitor, all on the falling system clock
    int clr_req = 0, clr_seen = 0;
    int cyc = 0, rise_cnt, fall_cnt, low_run, hp_err, cs_cycles, cs_falls;
    int cs_rise_cyc, done_cnt, done_bad, ovr_cnt, ovr_cs_bad;
    int fall_cyc [NB];
    logic [7:0] cap [NB];
    logic sclk_prev, cs_prev;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            din = 1'b0;
            sclk_prev = 1'b1;
            cs_prev = 1'b0;
        end else begin
            if (clr_req != clr_seen) begin
                clr_seen = clr_req;
                rise_cnt = 0; fall_cnt = 0; low_run = 0; hp_err = 0;
                cs_cycles = 0; cs_falls = 0; cs_rise_cyc = -1;
                done_cnt = 0; done_bad = 0; ovr_cnt = 0; ovr_cs_bad = 0;
                for (int i = 0; i < NB; i++) begin
                    fall_cyc[i] = 0;
                    cap[i] = '0;
                end
                sclk_prev = sclk;
            end
            if (cs) cs_cycles++;
            if (cs && !cs_prev) cs_rise_cyc = cyc;
            if (!cs && cs_prev) begin
                cs_falls++;
                if (!frame_done) done_bad++;
            end
            if (frame_done) begin
                done_cnt++;
                if (cs) done_bad++;
            end
            if (overrun) begin
                ovr_cnt++;
                if (!cs) ovr_cs_bad++;
            end
            if (!sclk) low_run++;
            if (sclk_prev && !sclk) begin
                if (fall_cnt / 8 < NB) begin
                    if (fall_cnt % 8 == 0) fall_cyc[fall_cnt / 8] = cyc;
                    din = rx_pat(seed, fall_cnt / 8)[7 - fall_cnt % 8];
                end
                fall_cnt++;
            end
            if (!sclk_prev && sclk) begin
                if (low_run != H) hp_err++;
                low_run = 0;
                if (rise_cnt / 8 < NB) cap[rise_cnt / 8][7 - rise_cnt % 8] = dout;
                rise_cnt++;
            end
            sclk_prev = sclk;
            cs_prev = cs;
        end
    end

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic clear_mon();
        clr_req++;
        @(negedge clk);
    endtask

    task automatic load_tx(int s);
        for (int i = 0; i < NB; i++) begin
            step();
            tx_wr_en = 1'b1; tx_wr_addr = 5'(i); tx_wr_data = tx_pat(s, i);
        end
        step();
        tx_wr_en = 1'b0;
        seed = s;
    endtask

    task automatic pulse_sync();
        step(); frame_sync = 1'b1;
        step(); frame_sync = 1'b0;
    endtask

    task automatic wait_done(int limit);
        for (int i = 0; i < limit && done_cnt == 0; i++) @(negedge clk);
    endtask

    task automatic check_bytes(string req);
        int bad_tx = 0, bad_rx = 0;
        for (int i = 0; i < NB; i++) begin
            if (cap[i] != tx_pat(seed, i)) bad_tx++;
            step(); rx_rd_addr = 5'(i); #1;
            if (rx_rd_data != rx_pat(seed, i)) bad_rx++;
        end
        check({req, " R3 dout bytes MSB first"}, bad_tx, 0);
        check({req, " R4 R9 rx bytes stored"}, bad_rx, 0);
        check({req, " R3 half period"}, hp_err, 0);
        check({req, " R3 clock count"}, fall_cnt, NB * 8);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 cs low", int'(cs), 0);
        check("R1 sclk high", int'(sclk), 1);
        check("R1 done low", int'(frame_done), 0);
        check("R1 overrun low", int'(overrun), 0);
    endtask

    task automatic t_basic(int s);
        int spacing_bad = 0;
        load_tx(s);
        clear_mon();
        step(); frame_sync = 1'b1;
        @(negedge clk);
        check("R2 cs not yet", int'(cs), 0);
        @(negedge clk);
        check("R2 cs raised", int'(cs), 1);
        step(); frame_sync = 1'b0;
        wait_done(FRAME_LEN + 20);
        @(negedge clk);
        check("R2 first fall delay", fall_cyc[0] - cs_rise_cyc, H + 1);
        for (int k = 1; k < NB; k++)
            if (fall_cyc[k] - fall_cyc[k-1] != S) spacing_bad++;
        check("R5 slot spacing", spacing_bad, 0);
        check("R7 frame length", cs_cycles, FRAME_LEN);
        check("R7 one done pulse", done_cnt, 1);
        check("R7 done with cs fall", done_bad, 0);
        check("R8 no overrun", ovr_cnt, 0);
        check_bytes("basic");
    endtask

    task automatic t_busy_skip(int s);
        load_tx(s);
        clear_mon();
        step(); busy = 1'b1;
        pulse_sync();
        step(); step();
        busy = 1'b0;
        wait_done(FRAME_LEN + S + 20);
        @(negedge clk);
        check("R6 skip delays first byte", fall_cyc[0] - cs_rise_cyc, S + H + 1);
        check("R6 frame length with skip", cs_cycles, FRAME_LEN + S);
        check("R6 one done pulse", done_cnt, 1);
        check_bytes("busy");
    endtask

    task automatic t_overrun(int s);
        load_tx(s);
        clear_mon();
        pulse_sync();
        for (int i = 0; i < 300; i++) step();
        frame_sync = 1'b1;
        step();
        frame_sync = 1'b0;
        clear_mon();
        wait_done(FRAME_LEN + 20);
        @(negedge clk);
        check("R8 overrun pulse", ovr_cnt, 1);
        check("R8 cs held on overrun", ovr_cs_bad, 0);
        check("R8 restarted frame length", cs_cycles, FRAME_LEN);
        check("R8 single cs fall", cs_falls, 1);
        check_bytes("overrun");
    endtask

    task automatic t_held_sync(int s);
        load_tx(s);
        clear_mon();
        step(); frame_sync = 1'b1;
        for (int i = 0; i < FRAME_LEN + 200; i++) step();
        frame_sync = 1'b0;
        for (int i = 0; i < 50; i++) step();
        @(negedge clk);
        check("R10 one frame for held sync", done_cnt, 1);
        check("R10 no overrun for held sync", ovr_cnt, 0);
        check("R10 cs low after release", int'(cs), 0);
    endtask

    initial begin
        #(8 * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic(1);
        t_basic(2);
        t_busy_skip(3);
        t_overrun(4);
        t_held_sync(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule